// File: doc/BRIEF.md
# Framed Serial Message Loader

The loader sits between a UART receiver and a 128K-byte external SRAM. It takes received bytes, one per valid strobe, and turns them into single-cycle SRAM writes. Each write carries a 16-bit address, a bank select for the upper or lower 64K half, and the data byte. While it is idle, the loader looks only for a sync byte. After the sync byte it stores a fixed-length header in the upper bank. It then stores message text in the lower bank until the text pointer has covered the whole 64K address space and wrapped to zero. At that point it asks the system to restart.

While a load runs, the block drives two busy flags, one for the header phase and one for the text phase. Display logic uses them to hold back its end-of-message handling. The sync byte also starts two display-side effects. A force-all-on flag tells the display path to OR all ones into its pixel data. A one-cycle fade request selects fading as the only active effect.

Top module: `msg_loader`

## Requirements
- R1: After synchronous reset, every output is 0, and the first header byte is later written to address 0x0000.
- R2: While idle, a received byte other than the sync value 0x55 causes no write and leaves both busy flags and all other flags at 0.
- R3: A 0x55 byte received while idle is not written. In the next cycle, hdr_busy and force_on are 1 and fade_req is 1 for exactly that one cycle.
- R4: Each byte received in the header phase appears in the next cycle as a write with mem_we = 1, mem_hi_bank = 1, mem_addr equal to the header pointer, and mem_wdata equal to the byte. The pointer then advances by one.
- R5: After 387 header bytes (addresses 0x0000 to 0x0182), hdr_busy falls and txt_busy rises in the cycle of the last header write. The next byte received is written to address 0x0000.
- R6: Each byte received in the text phase is written in the next cycle with mem_hi_bank = 0, at successive addresses starting from 0x0000.
- R7: A 0x55 byte received in the header or text phase is stored as ordinary data and does not restart framing.
- R8: The text byte written at 0xFFFF completes the load. In the cycle of that write, restart_req rises and txt_busy falls. restart_req then stays high until reset, and later bytes, including 0x55, cause no write.
- R9: force_on stays at 1 from the sync byte until reset.
- R10: mem_we is high for exactly one cycle per accepted byte. It is low in any cycle that follows a cycle without a received byte, and the write pointer does not move across such gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: rx_byte holds a received byte |
| rx_byte | input | 8 | Received byte |
| mem_we | output | 1 | SRAM write pulse |
| mem_addr | output | 16 | SRAM address within the selected bank |
| mem_hi_bank | output | 1 | 1 selects the upper 64K bank |
| mem_wdata | output | 8 | SRAM write data |
| hdr_busy | output | 1 | Header reception in progress |
| txt_busy | output | 1 | Text reception in progress |
| force_on | output | 1 | Display data is to be forced to all ones |
| fade_req | output | 1 | One-cycle request to make fading the sole effect |
| restart_req | output | 1 | Load complete; system restart requested (held) |

## Verification
The hardest state to reach from the ports is load completion. It happens only after the sync byte, 387 header bytes and a full 65,536-byte text stream. The bench drives the complete stream back-to-back and inserts idle gaps at scattered points. It also places a 0x55 byte inside both the header and the text. This checks the final write at 0xFFFF, the restart flag and the behaviour after completion against a cycle-level model at every step.

// File: rtl/msgld_pkg.sv
package msgld_pkg;

    // Load phase carried between the sequencer and the flag logic
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HDR  = 2'd1,
        PH_TXT  = 2'd2,
        PH_DONE = 2'd3
    } ld_phase_e;

    // Status flags presented at the block edge
    typedef struct packed {
        logic hdr_busy;
        logic txt_busy;
        logic force_on;
        logic fade_req;
        logic restart_req;
    } ld_flags_t;

    // Busy pair {header, text} for a phase
    function automatic logic [1:0] busy_of(input ld_phase_e ph);
        case (ph)
            PH_HDR:  return 2'b10;
            PH_TXT:  return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/msgld_sequencer.sv
module msgld_sequencer
    import msgld_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned HDR_LEN  = 387,
    parameter int unsigned SYNC_VAL = 'h55
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    output ld_phase_e         phase_o,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              wr_go,
    output logic              wr_hi,
    output logic              sync_hit,
    output logic              wrap_hit
);
    localparam logic [ADDR_W-1:0] HDR_END  = ADDR_W'(HDR_LEN);
    localparam logic [DATA_W-1:0] SYNC_B   = DATA_W'(SYNC_VAL);
    localparam logic [ADDR_W-1:0] PTR_LAST = {ADDR_W{1'b1}};

    ld_phase_e         ph_q, ph_d;
    logic [ADDR_W-1:0] ptr_q, ptr_d, ptr_inc;

    assign ptr_inc = ptr_q + 1'b1;

    always_comb begin
        ph_d     = ph_q;
        ptr_d    = ptr_q;
        wr_go    = 1'b0;
        wr_hi    = 1'b0;
        sync_hit = 1'b0;
        wrap_hit = 1'b0;
        case (ph_q)
            PH_IDLE: begin
                if (rx_valid && rx_byte == SYNC_B) begin
                    sync_hit = 1'b1;
                    ph_d     = PH_HDR;
                    ptr_d    = '0;
                end
            end
            PH_HDR: begin
                if (rx_valid) begin
                    wr_go = 1'b1;
                    wr_hi = 1'b1;
                    ptr_d = ptr_inc;
                    if (ptr_inc == HDR_END) begin
                        ph_d  = PH_TXT;
                        ptr_d = '0;
                    end
                end
            end
            PH_TXT: begin
                if (rx_valid) begin
                    wr_go = 1'b1;
                    ptr_d = ptr_inc;
                    if (ptr_q == PTR_LAST) begin
                        ph_d     = PH_DONE;
                        wrap_hit = 1'b1;
                    end
                end
            end
            default: begin
                ph_d = PH_DONE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            ptr_q <= '0;
        end else begin
            ph_q  <= ph_d;
            ptr_q <= ptr_d;
        end
    end

    assign phase_o = ph_q;
    assign ptr_o   = ptr_q;

    // R5: header pointer never reaches the header length while in header phase
    assert_hdr_ptr_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_HDR) |-> (ptr_q < HDR_END));

    // R8: the final text byte moves the sequencer to completion
    assert_wrap_done_R8: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_TXT && rx_valid && ptr_q == PTR_LAST) |=> (ph_q == PH_DONE));

    // R8: completion is terminal until reset
    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_DONE) |=> (ph_q == PH_DONE));

    // R10: without a received byte the pointer holds
    assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!rx_valid && ph_q != PH_IDLE) |=> $stable(ptr_q));

endmodule

// File: rtl/msgld_write_port.sv
module msgld_write_port #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_go,
    input  logic              wr_hi,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_hi_bank,
    output logic [DATA_W-1:0] mem_wdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we      <= 1'b0;
            mem_addr    <= '0;
            mem_hi_bank <= 1'b0;
            mem_wdata   <= '0;
        end else begin
            mem_we <= wr_go;
            if (wr_go) begin
                mem_addr    <= wr_addr;
                mem_hi_bank <= wr_hi;
                mem_wdata   <= wr_data;
            end
        end
    end

    // R4 / R6: back-to-back writes never repeat an address
    assert_addr_advances_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr != $past(mem_addr)));

endmodule

// File: rtl/msgld_flags.sv
module msgld_flags
    import msgld_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ld_phase_e phase,
    input  logic      sync_hit,
    input  logic      wrap_hit,
    output ld_flags_t flags
);
    logic       force_q, fade_q, restart_q;
    logic [1:0] busy;

    assign busy = busy_of(phase);

    always_ff @(posedge clk) begin
        if (rst) begin
            force_q   <= 1'b0;
            fade_q    <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            fade_q <= sync_hit;
            if (sync_hit) force_q   <= 1'b1;
            if (wrap_hit) restart_q <= 1'b1;
        end
    end

    always_comb begin
        flags.hdr_busy    = busy[1];
        flags.txt_busy    = busy[0];
        flags.force_on    = force_q;
        flags.fade_req    = fade_q;
        flags.restart_req = restart_q;
    end

    // R3: fade request lasts a single cycle
    assert_fade_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        fade_q |=> !fade_q);

    // R9: force-on holds once set
    assert_force_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        force_q |=> force_q);

    // R8: restart request holds once set
    assert_restart_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        restart_q |=> restart_q);

    // R5: never busy in both phases
    assert_busy_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(busy));

endmodule

// File: rtl/msg_loader.sv
module msg_loader
    import msgld_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned HDR_LEN  = 387,
    parameter int unsigned SYNC_VAL = 'h55
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_hi_bank,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              hdr_busy,
    output logic              txt_busy,
    output logic              force_on,
    output logic              fade_req,
    output logic              restart_req
);
    ld_phase_e         phase;
    logic [ADDR_W-1:0] ptr;
    logic              wr_go, wr_hi, sync_hit, wrap_hit;
    ld_flags_t         flags;

    msgld_sequencer #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .HDR_LEN (HDR_LEN),
        .SYNC_VAL(SYNC_VAL)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .rx_valid(rx_valid),
        .rx_byte (rx_byte),
        .phase_o (phase),
        .ptr_o   (ptr),
        .wr_go   (wr_go),
        .wr_hi   (wr_hi),
        .sync_hit(sync_hit),
        .wrap_hit(wrap_hit)
    );

    msgld_write_port #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_wr (
        .clk        (clk),
        .rst        (rst),
        .wr_go      (wr_go),
        .wr_hi      (wr_hi),
        .wr_addr    (ptr),
        .wr_data    (rx_byte),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_hi_bank(mem_hi_bank),
        .mem_wdata  (mem_wdata)
    );

    msgld_flags u_flg (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .sync_hit(sync_hit),
        .wrap_hit(wrap_hit),
        .flags   (flags)
    );

    assign hdr_busy    = flags.hdr_busy;
    assign txt_busy    = flags.txt_busy;
    assign force_on    = flags.force_on;
    assign fade_req    = flags.fade_req;
    assign restart_req = flags.restart_req;

    // R2 / R8: bytes arriving outside a load phase produce no write
    assert_no_write_outside_R2: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !hdr_busy && !txt_busy) |=> !mem_we);

    // R10: every write pulse follows a received byte
    assert_write_has_byte_R10: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(rx_valid));

    // R4: upper-bank writes come only from the header phase
    assert_hi_bank_header_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_hi_bank) |-> $past(hdr_busy));

    // R8: restart rises only when text reception ends
    assert_restart_from_text_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(restart_req) |-> ($past(txt_busy) && !txt_busy));

endmodule

// File: tb/sim_msg_loader.sv
`timescale 1ns/1ps
module sim_msg_loader;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic        mem_we, mem_hi_bank, hdr_busy, txt_busy, force_on, fade_req, restart_req;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;

    always #2.5 clk = ~clk;

    msg_loader u0 (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_hi_bank(mem_hi_bank),
        .mem_wdata(mem_wdata), .hdr_busy(hdr_busy), .txt_busy(txt_busy),
        .force_on(force_on), .fade_req(fade_req), .restart_req(restart_req)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit ended  = 0;

    // Reference model state (0 idle, 1 header, 2 text, 3 done)
    int          m_phase = 0;
    int          m_ptr   = 0;
    logic        e_we = 0, e_hi = 0, e_force = 0, e_fade = 0, e_restart = 0;
    logic [15:0] e_addr = 0;
    logic [7:0]  e_data = 0;

    task automatic model(input logic v, input logic [7:0] b);
        e_we   = 0;
        e_fade = 0;
        if (v) begin
            case (m_phase)
                0: if (b == 8'h55) begin m_phase = 1; m_ptr = 0; e_force = 1; e_fade = 1; end
                1: begin
                    e_we = 1; e_hi = 1; e_addr = 16'(m_ptr); e_data = b;
                    m_ptr = m_ptr + 1;
                    if (m_ptr == 387) begin m_phase = 2; m_ptr = 0; end
                end
                2: begin
                    e_we = 1; e_hi = 0; e_addr = 16'(m_ptr); e_data = b;
                    if (m_ptr == 65535) begin m_phase = 3; e_restart = 1; end
                    m_ptr = (m_ptr + 1) % 65536;
                end
                default: ;
            endcase
        end
    endtask

    task automatic check(input string tag);
        logic [30:0] act, exp;
        act = {mem_we, mem_addr, mem_hi_bank, mem_wdata, hdr_busy, txt_busy, force_on, fade_req, restart_req};
        exp = {e_we, e_addr, e_hi, e_data, (m_phase == 1), (m_phase == 2), e_force, e_fade, e_restart};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (we,addr,hi,data,hb,tb,fo,fd,rr) at cycle %0d",
                     tag, act, exp, cycles);
        end
    endtask

    task automatic step(input logic v, input logic [7:0] b, input string tag);
        @(negedge clk);
        check(tag);
        rx_valid = v;
        rx_byte  = b;
        model(v, b);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual cycle %0d expected completion earlier", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state observed on the first step
        step(0, 8'h00, "R1");
        // R2: non-sync bytes in idle, including near-misses
        step(1, 8'h54, "R2");
        step(1, 8'hAA, "R2");
        step(0, 8'h55, "R2");
        step(1, 8'h56, "R2");
        step(1, 8'h00, "R2");
        step(1, 8'hFF, "R2");
        // R3: sync byte
        step(1, 8'h55, "R3");
        step(0, 8'h00, "R3");
        step(0, 8'h00, "R3");
        // R4/R7/R10: header stream with gaps and an embedded sync value
        for (int i = 0; i < 387; i++) begin
            if (i == 10 || i == 200) begin
                step(0, 8'hEE, "R10");
                step(0, 8'hEE, "R10");
            end
            if (i == 3 || i == 386) step(1, 8'h55, "R7");
            else step(1, 8'(i * 13 + 1), (i == 0) ? "R1" : "R4");
        end
        // R5: first text byte goes to address 0 in the lower bank
        step(0, 8'h00, "R5");
        // R6/R7/R9/R10: full text stream
        for (int i = 0; i < 65536; i++) begin
            if (i % 4096 == 17) step(0, 8'h33, "R10");
            if (i == 5 || i == 40000) step(1, 8'h55, "R7");
            else step(1, 8'(i) ^ 8'hA5, (i == 0) ? "R5" : ((i == 65535) ? "R8" : "R6"));
        end
        // R8/R9: after completion
        step(1, 8'h55, "R8");
        step(1, 8'h12, "R8");
        step(0, 8'h00, "R9");
        step(1, 8'h55, "R8");
        step(0, 8'h00, "R8");
        @(negedge clk);
        check("R8");
        finish_run();
    end
endmodule